// File: doc/BRIEF.md
# Processor Status Byte with Power-State Flags

This block keeps the 8-bit status byte of a small processor core. The byte holds the program page selection, two power-history flags and the three arithmetic flags. Software changes it in two ways: it can write the whole byte, or it can set or clear one bit chosen by index. The ALU loads fresh arithmetic flags after an instruction. One-cycle event strobes move the power-history flags. The page selection is also brought out as a ready-made base address, so the fetch logic can form jump and call targets.

The power-history flags live in a four-state machine whose encoding is the flag pair {TO, PD}:

- States: `PWR_RUN` (11), `PWR_SLEPT` (10), `PWR_TRIP_RUN` (01) and `PWR_TRIP_SLEPT` (00).
- Watchdog clear: goes to `PWR_RUN` from every state.
- Sleep entry: goes to `PWR_SLEPT` from every state.
- Watchdog time-out: goes from `PWR_RUN` or `PWR_TRIP_RUN` to `PWR_TRIP_RUN`, and from `PWR_SLEPT` or `PWR_TRIP_SLEPT` to `PWR_TRIP_SLEPT`.
- No event: the state holds.
- Reset: enters `PWR_RUN`.

Software has no path into this machine.

Top module: `status_reg_core`

## Requirements
- R1: While `rst_n` is low (power-up reset), the byte is 8'h18: page bits 000, TO=1, PD=1, and Z, DC and C all 0.
- R2: A byte write (`sw_wr_en`) loads bits 7:5 and 2:0 from `sw_wr_data` at the next edge. Bits 4 (TO) and 3 (PD) of the written data are ignored.
- R3: A bit operation sets (`sw_bit_set`) or clears (`sw_bit_clr`) the bit at index `sw_bit_idx`, where 0=C, 1=DC, 2=Z, 3=PD, 4=TO and 5..7=page bits 0..2. Indices 3 and 4 have no effect. Clear wins over set on the same bit. A byte write in the same cycle overrides both.
- R4: When `alu_upd_en` is high, Z, DC and C take `alu_flags` = {Z, DC, C}. This replaces whatever a software write or bit operation in the same cycle would have put there.
- R5: A watchdog-clear strobe sets TO=1 and PD=1.
- R6: A sleep strobe sets TO=1 and PD=0.
- R7: A watchdog time-out strobe clears TO to 0 and leaves PD unchanged.
- R8: When strobes coincide, time-out wins over sleep, and sleep wins over watchdog clear.
- R9: `page_sel` equals bits 7:5. `page_base` equals `page_sel` times 512 words, so 000 gives 0x000, 010 gives 0x400 and 011 gives 0x600.
- R10: A cycle with no write, bit operation, ALU update or strobe leaves the byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| sw_wr_en | input | 1 | Software byte write enable |
| sw_wr_data | input | 8 | Byte to write |
| sw_bit_set | input | 1 | Set the indexed bit |
| sw_bit_clr | input | 1 | Clear the indexed bit |
| sw_bit_idx | input | 3 | Bit index for set or clear |
| alu_upd_en | input | 1 | Load arithmetic flags from the ALU |
| alu_flags | input | 3 | {Z, DC, C} from the ALU |
| wdt_clear | input | 1 | Watchdog-clear event strobe |
| sleep_enter | input | 1 | Sleep-entry event strobe |
| wdt_timeout | input | 1 | Watchdog time-out event strobe |
| status_q | output | 8 | Current status byte |
| page_sel | output | 3 | Page-select bits |
| page_base | output | 12 | Word address of the selected page start |

## Verification
Some rules hold on every cycle, and the assertions watch those:

- Each strobe has the effect on the power-flag pair that its priority allows.
- A cycle with no event leaves that pair alone, whatever software does.
- An ALU update always leaves exactly the supplied flag bits.
- An idle cycle leaves the page field unchanged.

Other behaviour only shows up in the bench's scenarios. That covers the combined precedence of a byte write against bit operations and an ALU update in the same cycle, the silent dropping of writes aimed at bits 3 and 4, the full byte value after chains of strobes, and the page base address.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int STAT_W          = 8;
    localparam int BIT_C           = 0;
    localparam int BIT_DC          = 1;
    localparam int BIT_Z           = 2;
    localparam int BIT_PD          = 3;
    localparam int BIT_TO          = 4;
    localparam int PAGE_LSB        = 5;
    localparam int FLAG_W          = 3;
    localparam int PAGE_W          = STAT_W - PAGE_LSB;
    localparam int PAGE_SPAN_LOG2  = 9;
    localparam int ADDR_W          = PAGE_W + PAGE_SPAN_LOG2;
    localparam int IDX_W           = $clog2(STAT_W);

    // State encoding is the flag pair {TO, PD}
    typedef enum logic [1:0] {
        PWR_RUN        = 2'b11,
        PWR_SLEPT      = 2'b10,
        PWR_TRIP_RUN   = 2'b01,
        PWR_TRIP_SLEPT = 2'b00
    } pwr_state_t;
endpackage

// File: rtl/power_flag_fsm.sv
module power_flag_fsm
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_clear,
    input  logic sleep_enter,
    input  logic wdt_timeout,
    output logic to_flag,
    output logic pd_flag
);
    pwr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wdt_timeout) begin
            unique case (state_q)
                PWR_RUN, PWR_TRIP_RUN:     state_d = PWR_TRIP_RUN;
                PWR_SLEPT, PWR_TRIP_SLEPT: state_d = PWR_TRIP_SLEPT;
                default:                   state_d = PWR_RUN;
            endcase
        end else if (sleep_enter) begin
            state_d = PWR_SLEPT;
        end else if (wdt_clear) begin
            state_d = PWR_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PWR_RUN:        begin to_flag = 1'b1; pd_flag = 1'b1; end
            PWR_SLEPT:      begin to_flag = 1'b1; pd_flag = 1'b0; end
            PWR_TRIP_RUN:   begin to_flag = 1'b0; pd_flag = 1'b1; end
            PWR_TRIP_SLEPT: begin to_flag = 1'b0; pd_flag = 1'b0; end
            default:        begin to_flag = 1'b1; pd_flag = 1'b1; end
        endcase
    end

    assert_timeout_clears_to_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> (!to_flag && pd_flag == $past(pd_flag)));
    assert_sleep_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter && !wdt_timeout) |=> (to_flag && !pd_flag));
    assert_clear_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clear && !sleep_enter && !wdt_timeout) |=> (to_flag && pd_flag));
    assert_power_flags_hw_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_clear && !sleep_enter && !wdt_timeout) |=> ($stable(to_flag) && $stable(pd_flag)));
endmodule

// File: rtl/sw_field_reg.sv
module sw_field_reg #(
    parameter int          WIDTH     = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    input  logic             hw_load,
    input  logic [WIDTH-1:0] hw_data,
    output logic [WIDTH-1:0] field_q
);
    logic [WIDTH-1:0] field_d;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            if (hw_load)          field_d[b] = hw_data[b];
            else if (wr_en)       field_d[b] = wr_data[b];
            else if (clr_mask[b]) field_d[b] = 1'b0;
            else if (set_mask[b]) field_d[b] = 1'b1;
            else                  field_d[b] = field_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) field_q <= RESET_VAL;
        else        field_q <= field_d;
    end

    assert_hw_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_load |=> (field_q == $past(hw_data)));
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_load && !wr_en && set_mask == '0 && clr_mask == '0) |=> $stable(field_q));
endmodule

// File: rtl/status_reg_core.sv
module status_reg_core
    import sreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr_en,
    input  logic [STAT_W-1:0]   sw_wr_data,
    input  logic                sw_bit_set,
    input  logic                sw_bit_clr,
    input  logic [IDX_W-1:0]    sw_bit_idx,
    input  logic                alu_upd_en,
    input  logic [FLAG_W-1:0]   alu_flags,
    input  logic                wdt_clear,
    input  logic                sleep_enter,
    input  logic                wdt_timeout,
    output logic [STAT_W-1:0]   status_q,
    output logic [PAGE_W-1:0]   page_sel,
    output logic [ADDR_W-1:0]   page_base
);
    logic [STAT_W-1:0] idx_onehot;
    logic [STAT_W-1:0] set_vec, clr_vec;
    logic [FLAG_W-1:0] arith_q;
    logic              to_flag, pd_flag;

    // Bit operations are dropped when a byte write is present
    always_comb begin
        idx_onehot = '0;
        idx_onehot[sw_bit_idx] = 1'b1;
        clr_vec = (sw_bit_clr && !sw_wr_en) ? idx_onehot : '0;
        set_vec = (sw_bit_set && !sw_wr_en) ? idx_onehot : '0;
    end

    sw_field_reg #(.WIDTH(FLAG_W), .RESET_VAL('0)) u_arith (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sw_wr_en),
        .wr_data  (sw_wr_data[BIT_Z:BIT_C]),
        .set_mask (set_vec[BIT_Z:BIT_C]),
        .clr_mask (clr_vec[BIT_Z:BIT_C]),
        .hw_load  (alu_upd_en),
        .hw_data  (alu_flags),
        .field_q  (arith_q)
    );

    sw_field_reg #(.WIDTH(PAGE_W), .RESET_VAL('0)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sw_wr_en),
        .wr_data  (sw_wr_data[STAT_W-1:PAGE_LSB]),
        .set_mask (set_vec[STAT_W-1:PAGE_LSB]),
        .clr_mask (clr_vec[STAT_W-1:PAGE_LSB]),
        .hw_load  (1'b0),
        .hw_data  ('0),
        .field_q  (page_sel)
    );

    power_flag_fsm u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wdt_clear   (wdt_clear),
        .sleep_enter (sleep_enter),
        .wdt_timeout (wdt_timeout),
        .to_flag     (to_flag),
        .pd_flag     (pd_flag)
    );

    assign status_q  = {page_sel, to_flag, pd_flag, arith_q};
    assign page_base = {page_sel, {PAGE_SPAN_LOG2{1'b0}}};
endmodule

// File: tb/status_reg_core_tb.sv
`timescale 1ns/1ps
module status_reg_core_tb;
    import sreg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [7:0]  sw_wr_data = '0;
    logic        sw_bit_set = 1'b0, sw_bit_clr = 1'b0;
    logic [2:0]  sw_bit_idx = '0;
    logic        alu_upd_en = 1'b0;
    logic [2:0]  alu_flags = '0;
    logic        wdt_clear = 1'b0, sleep_enter = 1'b0, wdt_timeout = 1'b0;
    logic [7:0]  status_q;
    logic [2:0]  page_sel;
    logic [11:0] page_base;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    status_reg_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_bit_set(sw_bit_set), .sw_bit_clr(sw_bit_clr), .sw_bit_idx(sw_bit_idx),
        .alu_upd_en(alu_upd_en), .alu_flags(alu_flags),
        .wdt_clear(wdt_clear), .sleep_enter(sleep_enter), .wdt_timeout(wdt_timeout),
        .status_q(status_q), .page_sel(page_sel), .page_base(page_base)
    );

    // {wr_en, wr_data[8], set, clr, idx[3], alu_en, alu[3], wclr, sleep, tmo, expected[8]}
    localparam int NVEC = 17;
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 8'hE7, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'hFF}, // R2 bits 4,3 ignored
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 8'hF7}, // R6 sleep
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 8'hE7}, // R7 timeout while asleep
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 8'hFF}, // R5 watchdog clear
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 8'hEF}, // R7 timeout keeps PD
        {1'b1, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 3'b101, 1'b0, 1'b0, 1'b0, 8'h0D}, // R4 ALU over write
        {1'b0, 8'h00, 1'b1, 1'b0, 3'd6, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h4D}, // R3 set page bit 1
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h4C}, // R3 clear C
        {1'b0, 8'h00, 1'b1, 1'b0, 3'd4, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h4C}, // R3 set TO ignored
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd3, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h4C}, // R3 clear PD ignored
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 8'h54}, // R8 sleep over clear
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 8'h44}, // R8 timeout over all
        {1'b1, 8'h60, 1'b1, 1'b0, 3'd1, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h60}, // R3 write over set
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 8'h62}, // R4 ALU only
        {1'b0, 8'h00, 1'b1, 1'b1, 3'd5, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h42}, // R3 clear over set
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h42}, // R10 idle
        {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 8'h5A}  // R5 clear from tripped
    };
    localparam int VREQ [NVEC] = '{2, 6, 7, 5, 7, 4, 3, 3, 3, 3, 8, 8, 3, 4, 3, 10, 5};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sw_wr_en = 1'b0; sw_wr_data = '0; sw_bit_set = 1'b0; sw_bit_clr = 1'b0;
        sw_bit_idx = '0; alu_upd_en = 1'b0; alu_flags = '0;
        wdt_clear = 1'b0; sleep_enter = 1'b0; wdt_timeout = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset byte", 32'(status_q), 32'h18);
        check("R9 reset page base", 32'(page_base), 32'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 hold after reset", 32'(status_q), 32'h18);

        for (int i = 0; i < NVEC; i++) begin
            {sw_wr_en, sw_wr_data, sw_bit_set, sw_bit_clr, sw_bit_idx,
             alu_upd_en, alu_flags, wdt_clear, sleep_enter, wdt_timeout} = VEC[i][28:8];
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VREQ[i], i), 32'(status_q), 32'(VEC[i][7:0]));
        end
        idle_inputs();

        check("R9 page_sel 010", 32'(page_sel), 32'h2);
        check("R9 page base 010", 32'(page_base), 32'h400);

        sw_wr_en = 1'b1; sw_wr_data = 8'h60;
        @(negedge clk);
        idle_inputs();
        check("R9 page base 011", 32'(page_base), 32'h600);

        sw_wr_en = 1'b1; sw_wr_data = 8'hE0;
        @(negedge clk);
        idle_inputs();
        check("R9 page base 111", 32'(page_base), 32'hE00);

        wdt_timeout = 1'b1;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        #1;
        check("R1 reset mid-run", 32'(status_q), 32'h18);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 byte after release", 32'(status_q), 32'h18);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule